// File: doc/BRIEF.md
# I/O Cycle Recovery Timer

This block keeps consecutive I/O bus cycles a programmable distance apart. Each I/O address strobe starts a new interval. The block measures that interval in bus clocks and withholds permission for the next I/O cycle until the interval is over. The spacing counts from the start of one I/O cycle to the start of the next, not from the end of the earlier cycle.

A bus sequencer holds `io_req` while it has an I/O cycle waiting. It may issue the strobe in any cycle during which `io_grant` is high. Memory cycles pass straight through the sequencer and are reported on `mem_strobe` only. They do not touch the timer.

The spacing comes from a 3-bit code held in an 8-bit configuration register. That register can be written at any time.

Top module: `io_recovery_timer`

## Requirements
- R1: With code 0 the spacing is one clock. When `io_req` is held, `io_grant` is already high in the cycle right after the I/O strobe edge.
- R2: With codes 1 to 7 the spacing is D = 2^code clocks (2, 4, 8, 16, 32, 64, 128). After a strobe sampled at edge k, `io_grant` first rises at edge k+D-1, so the next strobe can land at edge k+D or later.
- R3: An I/O strobe always restarts the interval, even while an earlier interval is still running. The new spacing is counted from that strobe.
- R4: Reset loads code 5 into the register, which gives a spacing of 32 clocks.
- R5: The code sits in bits 2:0 of `cfg_wdata` and is stored on an edge where `cfg_wr` is high. Bits 7:3 are ignored.
- R6: The code is sampled at the strobe edge. A register write made during a running interval leaves that interval's length unchanged and takes effect from the next strobe on.
- R7: Memory strobes neither stall nor restart nor lengthen a running interval.
- R8: `io_grant` is high only when `io_req` was high at the edge that set it, and never in the same cycle as `busy`.
- R9: `busy` is high from the strobe edge (for codes 1 to 7) until edge k+D-1, where it falls.
- R10: While reset is held and in the cycle it ends, `busy` and `io_grant` are low. With `io_req` held, `io_grant` rises on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write data; the code is in bits 2:0 |
| io_req | input | 1 | An I/O cycle is waiting to start |
| io_strobe | input | 1 | Address strobe of an I/O cycle |
| mem_strobe | input | 1 | Address strobe of a memory cycle (no effect) |
| io_grant | output | 1 | The next I/O strobe may be issued in this cycle |
| busy | output | 1 | A recovery interval is running |

## Verification
All eight codes are swept, each written with different junk in the upper data bits, and every case compares the first grant cycle against 2^code-1. This sweep separates a wrong decode, an off-by-one in the count and a write that leaks upper bits. Four further patterns each target one mistake:
- A write made in the middle of a 128-clock interval shows whether the length is taken from the live code or from the code latched at the strobe.
- A second strobe issued mid-interval shows whether the interval restarts.
- Memory strobes asserted on every cycle of an interval show whether memory traffic reloads or stalls the count.
- A long idle stretch with `io_req` low shows whether a grant is ever given without a request.

// File: rtl/iort_pkg.sv
package iort_pkg;

  // Number of clocks left after the strobe edge for a given code:
  // code 0 leaves nothing, code n leaves 2^n - 1.
  function automatic int unsigned reload_for(input int unsigned code);
    if (code == 0) return 0;
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/iort_cfg_reg.sv
module iort_cfg_reg #(
  parameter int CFG_W    = 8,
  parameter int CODE_W   = 3,
  parameter int CODE_LSB = 0,
  parameter int RST_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CODE_W-1:0] code
);

  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  // Only the code field is stored; the remaining data bits are dropped.
  logic unused_other_bits;
  assign unused_other_bits = ^{wr_data[CFG_W-1:CODE_MSB+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CODE_W'(RST_CODE);
    end else if (wr_en) begin
      code <= wr_data[CODE_MSB:CODE_LSB];
    end
  end

endmodule

// File: rtl/iort_code_decode.sv
module iort_code_decode #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 7
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  reload
);

  localparam int N_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] table_q [N_CODES];

  for (genvar i = 0; i < N_CODES; i++) begin : g_tbl
    assign table_q[i] = CNT_W'(iort_pkg::reload_for(i));
  end

  assign reload = table_q[code];

endmodule

// File: rtl/iort_interval_cnt.sv
module iort_interval_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] rem_q,
  output logic [CNT_W-1:0] rem_nxt
);

  // The count is reloaded on every I/O strobe and runs down to zero,
  // then stays there. The reload value is sampled only at the strobe.
  always_comb begin
    if (start) begin
      rem_nxt = reload;
    end else if (rem_q != '0) begin
      rem_nxt = rem_q - 1'b1;
    end else begin
      rem_nxt = rem_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_nxt;
  end

endmodule

// File: rtl/io_recovery_timer.sv
module io_recovery_timer #(
  parameter int CFG_W    = 8,
  parameter int CODE_W   = 3,
  parameter int CODE_LSB = 0,
  parameter int RST_CODE = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             io_req,
  input  logic             io_strobe,
  input  logic             mem_strobe,
  output logic             io_grant,
  output logic             busy
);

  localparam int MAX_EXP = (1 << CODE_W) - 1;
  localparam int CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [CODE_W-1:0] cur_code;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  rem_nxt;

  // Memory cycles are not involved in I/O spacing.
  logic unused_mem_strobe;
  assign unused_mem_strobe = mem_strobe;

  iort_cfg_reg #(
    .CFG_W(CFG_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .RST_CODE(RST_CODE)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_data(cfg_wdata), .code(cur_code)
  );

  iort_code_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .code(cur_code), .reload(reload)
  );

  iort_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(io_strobe), .reload(reload),
    .rem_q(rem_q), .rem_nxt(rem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      io_grant <= 1'b0;
    end else begin
      busy     <= (rem_nxt != '0);
      io_grant <= io_req && (rem_nxt == '0);
    end
  end

endmodule

// File: rtl/iort_checker.sv
module iort_checker #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic              io_strobe,
  input logic              mem_strobe,
  input logic              io_grant,
  input logic              busy,
  input logic [CODE_W-1:0] code,
  input logic [CNT_W-1:0]  rem
);

  p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
    io_grant |-> $past(io_req));

  p_grant_busy_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(io_grant && busy));

  p_long_code_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (io_strobe && code != '0) |=> busy);

  p_zero_code_free_r1: assert property (@(posedge clk) disable iff (rst)
    (io_strobe && code == '0) |=> !busy);

  p_mem_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_strobe && !io_strobe && rem != '0) |=> (rem == $past(rem) - 1'b1));

  p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(io_strobe));

endmodule

bind io_recovery_timer iort_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_strobe(io_strobe),
  .mem_strobe(mem_strobe), .io_grant(io_grant), .busy(busy),
  .code(cur_code), .rem(rem_q)
);

// File: tb/io_recovery_timer_tb_top.sv
`timescale 1ns/1ps
module io_recovery_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       io_req = 1'b0;
  logic       io_strobe = 1'b0;
  logic       mem_strobe = 1'b0;
  logic       io_grant;
  logic       busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  io_recovery_timer dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .io_req(io_req), .io_strobe(io_strobe), .mem_strobe(mem_strobe),
    .io_grant(io_grant), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_code(input logic [7:0] data);
    cfg_wr = 1'b1; cfg_wdata = data;
    tick();
    cfg_wr = 1'b0;
  endtask

  // One strobe; returns at the sample just after its edge (index 0).
  task automatic strobe_once();
    io_strobe = 1'b1;
    tick();
    io_strobe = 1'b0;
  endtask

  task automatic wait_grant(input string req, output int idx);
    idx = 0;
    while (!io_grant && idx < 400) begin
      if (io_grant && busy) check({req, " grant/busy overlap"}, 1, 0);
      tick();
      idx++;
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 400) begin tick(); guard++; end
    tick();
  endtask

  initial begin
    int idx;
    int exp;
    @(negedge clk);
    io_req = 1'b1;
    tick();
    check("R10 grant in reset", int'(io_grant), 0);
    check("R10 busy in reset", int'(busy), 0);
    rst = 1'b0;
    check("R10 grant as reset ends", int'(io_grant), 0);
    tick();
    check("R10 grant after reset", int'(io_grant), 1);
    check("R10 busy after reset", int'(busy), 0);

    // R4: default code gives 32 clocks
    strobe_once();
    check("R4 busy at start", int'(busy), 1);
    wait_grant("R4", idx);
    check("R4 default spacing", idx, 31);
    check("R9 busy low at grant", int'(busy), 0);
    wait_idle();

    // R1, R2, R5: sweep every code with junk in the upper bits
    for (int c = 0; c < 8; c++) begin
      write_code({5'(5'h13 + c * 3), 3'(c)});
      strobe_once();
      exp = (c == 0) ? 0 : (1 << c) - 1;
      check(c == 0 ? "R1 busy at start" : "R9 busy at start", int'(busy), c != 0 ? 1 : 0);
      wait_grant(c == 0 ? "R1" : "R2", idx);
      check(c == 0 ? "R1 spacing" : "R2 R5 spacing", idx, exp);
      wait_idle();
    end

    // R6: change code mid-interval
    write_code(8'h07);
    strobe_once();
    write_code(8'h01);
    wait_grant("R6", idx);
    check("R6 running interval keeps length", idx + 1, 127);
    wait_idle();
    strobe_once();
    wait_grant("R6", idx);
    check("R6 new code at next strobe", idx, 1);
    wait_idle();

    // R3: a second strobe restarts the interval
    write_code(8'h04);
    strobe_once();
    repeat (5) tick();
    strobe_once();
    check("R3 busy after restart", int'(busy), 1);
    wait_grant("R3", idx);
    check("R3 restart spacing", idx, 15);
    wait_idle();

    // R7: memory strobes every cycle
    write_code(8'h03);
    strobe_once();
    mem_strobe = 1'b1;
    wait_grant("R7", idx);
    mem_strobe = 1'b0;
    check("R7 memory strobes ignored", idx, 7);
    wait_idle();

    // R8: no grant without request
    io_req = 1'b0;
    tick();
    for (int i = 0; i < 10; i++) begin
      check("R8 no grant without request", int'(io_grant), 0);
      tick();
    end
    io_req = 1'b1;
    tick();
    check("R8 grant returns with request", int'(io_grant), 1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule